// File: doc/BRIEF.md
# Full-burst pixel-model memory scheduler

This block sits between a per-pixel background-model update stage and an external memory controller's command and data ports. Stored pixel models stream out of a read queue towards the update stage, one per processed pixel. Each updated model goes back through a write queue into a small staging queue. Memory traffic is started by one event only: the staging queue becoming full. The block then writes the staged contents as a fixed set of full-length write bursts. Straight after that, it issues the same number of read bursts to top the read queue back up. Because the staging queue can only fill once the same number of models has left the read queue, every access has full length, and the refill always finds room.

After reset the update stage is held off while the read queue is filled from the start of the model area. The block then waits for a rising edge on vertical sync, so processing starts outside active video. Write and read addresses are kept by separate counters. Each counter steps by one burst and wraps at the end of the frame's model area. If the update stage takes a model from an empty read queue while enabled, a sticky error flag is raised.

Top module: `mdl_burst_sched`

## Requirements
- R1: After reset, `proc_en_o` is low and only read commands (`mem_cmd_write_o` = 0) are issued, at word addresses 0, BURST_LEN, 2*BURST_LEN and so on, until RD_DEPTH words have been requested; no write command is issued during this fill.
- R2: Once the fill is complete, `proc_en_o` stays low until the first clock edge that samples `vsync_i` high after having sampled it low. `proc_en_o` is high from that edge on. While `proc_en_o` is low, `mdl_rd_avail_o` is low.
- R3: While enabled, `mdl_rd_data_o` shows the oldest word returned by memory and not yet taken, with `mdl_rd_avail_o` high. Each cycle with `mdl_rd_take_i` high removes exactly that word.
- R4: No write command is issued until STAGE_BURSTS*BURST_LEN updated models have been pushed since the previous write set.
- R5: When the staging queue is full, the block issues STAGE_BURSTS write commands (`mem_cmd_write_o` = 1). Each command is followed by exactly BURST_LEN data beats, which carry the models in push order to consecutive word addresses.
- R6: After the last write beat, the block issues exactly STAGE_BURSTS read commands, continuing the read address sequence, then idles until the staging queue is full again. Read data never arrives when the read queue has no room, so an unconsumed read queue holds exactly RD_DEPTH words.
- R7: A command, with its address and direction, stays asserted and unchanged until `mem_cmd_ready_i` is sampled high.
- R8: Each address counter advances by BURST_LEN word addresses per accepted command and returns to 0 after FRAME_WORDS-BURST_LEN.
- R9: `underflow_err_o` is 0 after reset. It becomes 1 on the clock edge after a take while enabled with an empty read queue, and then stays 1 until reset. A take while `proc_en_o` is low removes nothing.
- R10: Models pushed while a write burst is draining the staging queue are kept, and are written by a later write set in push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync_i | input | 1 | Vertical sync; a rising edge enables processing after the fill |
| proc_en_o | output | 1 | Update stage may process pixels |
| mdl_rd_avail_o | output | 1 | A stored model is available |
| mdl_rd_data_o | output | DATA_W | Oldest stored model |
| mdl_rd_take_i | input | 1 | Remove the presented model |
| mdl_wr_push_i | input | 1 | Push an updated model |
| mdl_wr_data_i | input | DATA_W | Updated model |
| underflow_err_o | output | 1 | Sticky read-queue underflow flag |
| mem_cmd_valid_o | output | 1 | Burst command valid |
| mem_cmd_ready_i | input | 1 | Controller accepts command |
| mem_cmd_write_o | output | 1 | 1 = write burst, 0 = read burst |
| mem_cmd_addr_o | output | ADDR_W | Burst start, in memory words |
| mem_wvalid_o | output | 1 | Write beat valid |
| mem_wready_i | input | 1 | Controller accepts write beat |
| mem_wdata_o | output | DATA_W | Write beat data |
| mem_rvalid_i | input | 1 | Read beat valid |
| mem_rdata_i | input | DATA_W | Read beat data |

## Verification
Two things can fall in the same cycle: the update stage taking and pushing models, and the scheduler draining the staging queue in a write burst or receiving read beats. The bench causes this by running many pixels back to back while the memory model stalls commands, write beats and read beats on different cycle patterns, so pushes land inside write bursts and takes land alongside refill beats. The outcome is judged from every model value the stage receives across a full address wrap and from the final memory image, which must show each word updated exactly as often as it was processed.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

   typedef enum logic [2:0] {
      ST_INIT_FILL   = 3'd0,
      ST_WAIT_VSYNC  = 3'd1,
      ST_IDLE        = 3'd2,
      ST_WRITE_BURST = 3'd3,
      ST_READ_BURST  = 3'd4
   } sched_st_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/mbs_fifo.sv
module mbs_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [PW-1:0] LAST_P = PW'(DEPTH - 1);
   localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

   initial begin
      assert (DEPTH >= 2) else $error("mbs_fifo: DEPTH must be at least 2");
      assert (W >= 1) else $error("mbs_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_n, rp_n;
   logic [CW-1:0] cnt;

   generate
      if (mbs_pkg::is_pow2(DEPTH)) begin : g_pow2
         assign wp_n = wp + 1'b1;
         assign rp_n = rp + 1'b1;
      end else begin : g_wrap
         assign wp_n = (wp == LAST_P) ? '0 : wp + 1'b1;
         assign rp_n = (rp == LAST_P) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp_n;
         if (pop)  rp <= rp_n;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign dout  = mem[rp];
   assign empty = (cnt == '0);
   assign full  = (cnt == FULL_C);

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   p_no_underrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/mbs_addr_gen.sv
module mbs_addr_gen #(
   parameter int ADDR_W = 24,
   parameter int STEP   = 8,
   parameter int LIMIT  = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);
   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LIMIT - STEP);

   initial begin
      assert (LIMIT % STEP == 0) else $error("mbs_addr_gen: LIMIT not a multiple of STEP");
      assert (LIMIT >= STEP) else $error("mbs_addr_gen: LIMIT below STEP");
      assert (longint'(LIMIT) <= (longint'(1) << ADDR_W)) else $error("mbs_addr_gen: ADDR_W too narrow");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    addr <= '0;
      else if (adv)  addr <= (addr == LAST_A) ? '0 : addr + STEP_A;
   end

   p_addr_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      addr <= LAST_A);
   p_addr_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(addr));

endmodule

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
   import mbs_pkg::*;
#(
   parameter int BURST_LEN    = 8,
   parameter int STAGE_BURSTS = 2,
   parameter int RD_DEPTH     = 64
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      vsync_i,
   input  logic      st_full_i,
   input  logic      cmd_ready_i,
   input  logic      wready_i,
   input  logic      rvalid_i,
   output sched_st_e state_o,
   output logic      cmd_valid_o,
   output logic      cmd_write_o,
   output logic      wvalid_o
);
   localparam int FILL_BURSTS = RD_DEPTH / BURST_LEN;
   localparam int BC_W        = $clog2(FILL_BURSTS + 1);
   localparam int RW_W        = $clog2(RD_DEPTH + 1);
   localparam int BT_W        = $clog2(BURST_LEN + 1);
   localparam logic [BC_W-1:0] FILL_B     = BC_W'(FILL_BURSTS);
   localparam logic [BC_W-1:0] STAGE_B    = BC_W'(STAGE_BURSTS);
   localparam logic [BC_W-1:0] STAGE_LAST = BC_W'(STAGE_BURSTS - 1);
   localparam logic [RW_W-1:0] FILL_W     = RW_W'(RD_DEPTH);
   localparam logic [RW_W-1:0] STAGE_W    = RW_W'(STAGE_BURSTS * BURST_LEN);
   localparam logic [BT_W-1:0] LAST_BEAT  = BT_W'(BURST_LEN - 1);

   initial begin
      assert (STAGE_BURSTS >= 1) else $error("mbs_ctrl: STAGE_BURSTS must be positive");
      assert (STAGE_BURSTS <= FILL_BURSTS) else $error("mbs_ctrl: staging larger than read queue");
   end

   sched_st_e       st;
   logic            vs_q, wdata_ph;
   logic [BT_W-1:0] beat;
   logic [BC_W-1:0] wb_cnt, rb_iss, tgt_b;
   logic [RW_W-1:0] rw_rcv, tgt_w;
   logic            in_rd, rd_cmd_want, rd_done;

   assign in_rd       = (st == ST_INIT_FILL) || (st == ST_READ_BURST);
   assign tgt_b       = (st == ST_INIT_FILL) ? FILL_B : STAGE_B;
   assign tgt_w       = (st == ST_INIT_FILL) ? FILL_W : STAGE_W;
   assign rd_cmd_want = in_rd && (rb_iss != tgt_b);
   assign rd_done     = in_rd && (rb_iss == tgt_b) && (rw_rcv == tgt_w);

   assign cmd_valid_o = ((st == ST_WRITE_BURST) && !wdata_ph) || rd_cmd_want;
   assign cmd_write_o = (st == ST_WRITE_BURST);
   assign wvalid_o    = (st == ST_WRITE_BURST) && wdata_ph;
   assign state_o     = st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_INIT_FILL;
         vs_q     <= 1'b0;
         wdata_ph <= 1'b0;
         beat     <= '0;
         wb_cnt   <= '0;
         rb_iss   <= '0;
         rw_rcv   <= '0;
      end else begin
         vs_q <= vsync_i;
         case (st)
            ST_INIT_FILL, ST_READ_BURST: begin
               if (rd_cmd_want && cmd_ready_i) rb_iss <= rb_iss + 1'b1;
               if (rvalid_i)                   rw_rcv <= rw_rcv + 1'b1;
               if (rd_done) begin
                  rb_iss <= '0;
                  rw_rcv <= '0;
                  st     <= (st == ST_INIT_FILL) ? ST_WAIT_VSYNC : ST_IDLE;
               end
            end
            ST_WAIT_VSYNC: begin
               if (vsync_i && !vs_q) st <= ST_IDLE;
            end
            ST_IDLE: begin
               if (st_full_i) begin
                  st       <= ST_WRITE_BURST;
                  wdata_ph <= 1'b0;
                  beat     <= '0;
                  wb_cnt   <= '0;
               end
            end
            ST_WRITE_BURST: begin
               if (!wdata_ph && cmd_ready_i) wdata_ph <= 1'b1;
               if (wdata_ph && wready_i) begin
                  if (beat == LAST_BEAT) begin
                     beat     <= '0;
                     wdata_ph <= 1'b0;
                     if (wb_cnt == STAGE_LAST) begin
                        wb_cnt <= '0;
                        st     <= ST_READ_BURST;
                     end else begin
                        wb_cnt <= wb_cnt + 1'b1;
                     end
                  end else begin
                     beat <= beat + 1'b1;
                  end
               end
            end
            default: st <= ST_INIT_FILL;
         endcase
      end
   end

   p_cmd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_write_o));
   p_fill_reads_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_INIT_FILL) |-> !(cmd_valid_o && cmd_write_o));
   p_rcv_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_rd |-> (rw_rcv <= tgt_w));

endmodule

// File: rtl/mdl_burst_sched.sv
module mdl_burst_sched
   import mbs_pkg::*;
#(
   parameter int DATA_W       = 256,
   parameter int ADDR_W       = 24,
   parameter int BURST_LEN    = 8,
   parameter int STAGE_BURSTS = 2,
   parameter int RD_DEPTH     = 64,
   parameter int WR_DEPTH     = 16,
   parameter int FRAME_WORDS  = 2073600
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vsync_i,
   output logic              proc_en_o,
   output logic              mdl_rd_avail_o,
   output logic [DATA_W-1:0] mdl_rd_data_o,
   input  logic              mdl_rd_take_i,
   input  logic              mdl_wr_push_i,
   input  logic [DATA_W-1:0] mdl_wr_data_i,
   output logic              underflow_err_o,
   output logic              mem_cmd_valid_o,
   input  logic              mem_cmd_ready_i,
   output logic              mem_cmd_write_o,
   output logic [ADDR_W-1:0] mem_cmd_addr_o,
   output logic              mem_wvalid_o,
   input  logic              mem_wready_i,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic              mem_rvalid_i,
   input  logic [DATA_W-1:0] mem_rdata_i
);
   localparam int STAGE_WORDS = STAGE_BURSTS * BURST_LEN;

   initial begin
      assert (BURST_LEN >= 2) else $error("mdl_burst_sched: BURST_LEN must be at least 2");
      assert (RD_DEPTH % BURST_LEN == 0) else $error("mdl_burst_sched: RD_DEPTH not burst aligned");
      assert (RD_DEPTH >= STAGE_WORDS) else $error("mdl_burst_sched: read queue below staging size");
      assert (FRAME_WORDS % BURST_LEN == 0) else $error("mdl_burst_sched: FRAME_WORDS not burst aligned");
      assert (FRAME_WORDS >= RD_DEPTH) else $error("mdl_burst_sched: frame smaller than read queue");
   end

   sched_st_e         state;
   logic              rf_empty, rf_full, rf_pop;
   logic              wf_empty, wf_full, wf_push;
   logic              st_empty, st_full, st_pop, mv;
   logic [DATA_W-1:0] wf_dout;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic              cmd_hs;

   assign proc_en_o      = (state != ST_INIT_FILL) && (state != ST_WAIT_VSYNC);
   assign mdl_rd_avail_o = proc_en_o && !rf_empty;
   assign rf_pop         = mdl_rd_take_i && proc_en_o && !rf_empty;
   assign wf_push        = mdl_wr_push_i && proc_en_o && !wf_full;
   assign mv             = !wf_empty && !st_full && (state != ST_WRITE_BURST);
   assign st_pop         = mem_wvalid_o && mem_wready_i;
   assign cmd_hs         = mem_cmd_valid_o && mem_cmd_ready_i;
   assign mem_cmd_addr_o = mem_cmd_write_o ? wr_addr : rd_addr;

   mbs_fifo #(.W(DATA_W), .DEPTH(RD_DEPTH)) i_rd_q (
      .clk(clk), .rst_n(rst_n), .push(mem_rvalid_i), .din(mem_rdata_i),
      .pop(rf_pop), .dout(mdl_rd_data_o), .empty(rf_empty), .full(rf_full));

   mbs_fifo #(.W(DATA_W), .DEPTH(WR_DEPTH)) i_wr_q (
      .clk(clk), .rst_n(rst_n), .push(wf_push), .din(mdl_wr_data_i),
      .pop(mv), .dout(wf_dout), .empty(wf_empty), .full(wf_full));

   mbs_fifo #(.W(DATA_W), .DEPTH(STAGE_WORDS)) i_stage_q (
      .clk(clk), .rst_n(rst_n), .push(mv), .din(wf_dout),
      .pop(st_pop), .dout(mem_wdata_o), .empty(st_empty), .full(st_full));

   mbs_ctrl #(.BURST_LEN(BURST_LEN), .STAGE_BURSTS(STAGE_BURSTS), .RD_DEPTH(RD_DEPTH)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .st_full_i(st_full),
      .cmd_ready_i(mem_cmd_ready_i), .wready_i(mem_wready_i), .rvalid_i(mem_rvalid_i),
      .state_o(state), .cmd_valid_o(mem_cmd_valid_o), .cmd_write_o(mem_cmd_write_o),
      .wvalid_o(mem_wvalid_o));

   mbs_addr_gen #(.ADDR_W(ADDR_W), .STEP(BURST_LEN), .LIMIT(FRAME_WORDS)) i_wr_addr (
      .clk(clk), .rst_n(rst_n), .adv(cmd_hs && mem_cmd_write_o), .addr(wr_addr));

   mbs_addr_gen #(.ADDR_W(ADDR_W), .STEP(BURST_LEN), .LIMIT(FRAME_WORDS)) i_rd_addr (
      .clk(clk), .rst_n(rst_n), .adv(cmd_hs && !mem_cmd_write_o), .addr(rd_addr));

   always_ff @(posedge clk) begin
      if (!rst_n)                                       underflow_err_o <= 1'b0;
      else if (mdl_rd_take_i && proc_en_o && rf_empty)  underflow_err_o <= 1'b1;
   end

   p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cmd_valid_o && !mem_cmd_ready_i |=> $stable(mem_cmd_addr_o));
   p_en_on_vsync_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(proc_en_o) |-> $past(vsync_i));
   p_beat_has_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wvalid_o |-> !st_empty);
   p_burst_drains_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_READ_BURST && $past(state) == ST_WRITE_BURST) |-> st_empty);
   p_read_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rvalid_i |-> !rf_full);
   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      underflow_err_o |=> underflow_err_o);

endmodule

// File: tb/test_mdl_burst_sched.sv
module test_mdl_burst_sched;
   localparam int DW = 32;
   localparam int AW = 12;
   localparam int BL = 4;
   localparam int SB = 2;
   localparam int RD = 16;
   localparam int WD = 8;
   localparam int FW = 32;
   localparam logic [DW-1:0] MASK = 32'hFFFF_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          vsync = 1'b0;
   logic          proc_en, rd_avail, take = 1'b0, push = 1'b0, uf_err;
   logic [DW-1:0] rd_data, wr_data = '0;
   logic          cmd_valid, cmd_ready = 1'b0, cmd_write;
   logic [AW-1:0] cmd_addr;
   logic          wvalid, wready = 1'b0, rvalid = 1'b0;
   logic [DW-1:0] wdata, rdata = '0;

   int n_chk = 0, n_fail = 0, cyc = 0;
   logic [DW-1:0] mem_m [FW];
   int rq_addr [256];
   int rq_h = 0, rq_t = 0, wr_cur = 0, wr_beat = 0;
   int wlog [64];
   int rlog [64];
   int n_wcmd = 0, n_rcmd = 0, n_wbeat = 0, hold_viol = 0;
   int pix = 0;
   bit pend = 1'b0, pend_wr = 1'b0;
   logic [AW-1:0] pend_addr = '0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   mdl_burst_sched #(.DATA_W(DW), .ADDR_W(AW), .BURST_LEN(BL), .STAGE_BURSTS(SB),
                     .RD_DEPTH(RD), .WR_DEPTH(WD), .FRAME_WORDS(FW)) i_mdl_burst_sched (
      .clk(clk), .rst_n(rst_n), .vsync_i(vsync), .proc_en_o(proc_en),
      .mdl_rd_avail_o(rd_avail), .mdl_rd_data_o(rd_data), .mdl_rd_take_i(take),
      .mdl_wr_push_i(push), .mdl_wr_data_i(wr_data), .underflow_err_o(uf_err),
      .mem_cmd_valid_o(cmd_valid), .mem_cmd_ready_i(cmd_ready), .mem_cmd_write_o(cmd_write),
      .mem_cmd_addr_o(cmd_addr), .mem_wvalid_o(wvalid), .mem_wready_i(wready),
      .mem_wdata_o(wdata), .mem_rvalid_i(rvalid), .mem_rdata_i(rdata));

   function automatic logic [DW-1:0] orig(input int i);
      return 32'hA000_0000 + DW'(i);
   endfunction

   function automatic logic [DW-1:0] exp_val(input int k);
      return orig(k % FW) ^ (((k / FW) % 2) != 0 ? MASK : '0);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endtask

   // memory model: decisions at the falling edge, taken up at the next rising edge
   initial for (int i = 0; i < FW; i++) mem_m[i] = orig(i);

   always @(negedge clk) begin
      if (!rst_n) begin
         cmd_ready = 1'b0; wready = 1'b0; rvalid = 1'b0;
      end else begin
         if (pend && (!cmd_valid || cmd_addr != pend_addr || cmd_write != pend_wr)) hold_viol++;
         if (rq_h != rq_t && (cyc % 4) != 1) begin
            rvalid = 1'b1;
            rdata  = mem_m[rq_addr[rq_h % 256] % FW];
            rq_h++;
         end else begin
            rvalid = 1'b0;
         end
         cmd_ready = (cyc % 3) != 0;
         if (cmd_valid && cmd_ready) begin
            if (cmd_write) begin
               if (n_wcmd < 64) wlog[n_wcmd] = int'(cmd_addr);
               n_wcmd++;
               wr_cur  = int'(cmd_addr);
               wr_beat = 0;
            end else begin
               if (n_rcmd < 64) rlog[n_rcmd] = int'(cmd_addr);
               n_rcmd++;
               for (int b = 0; b < BL; b++) begin
                  rq_addr[rq_t % 256] = int'(cmd_addr) + b;
                  rq_t++;
               end
            end
         end
         pend      = cmd_valid && !cmd_ready;
         pend_addr = cmd_addr;
         pend_wr   = cmd_write;
         wready = (cyc % 5) != 2;
         if (wvalid && wready) begin
            mem_m[(wr_cur + wr_beat) % FW] = wdata;
            wr_beat++;
            n_wbeat++;
         end
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // process n pixels: take a model, check it, push its update in the same cycle
   task automatic run_pixels(input int n);
      int done = 0;
      while (done < n) begin
         @(negedge clk);
         take = 1'b0; push = 1'b0;
         if (rd_avail) begin
            chk(rd_data == exp_val(pix), "R3", $sformatf("model value pixel %0d", pix),
                64'(rd_data), 64'(exp_val(pix)));
            take = 1'b1; push = 1'b1; wr_data = rd_data ^ MASK;
            pix++; done++;
         end
      end
      @(negedge clk);
      take = 1'b0; push = 1'b0;
   endtask

   task automatic t_reset();
      wait_cyc(2);
      chk(proc_en == 1'b0, "R1", "proc_en in reset", 64'(proc_en), 0);
      chk(uf_err == 1'b0, "R9", "error flag in reset", 64'(uf_err), 0);
      chk(rd_avail == 1'b0, "R2", "avail in reset", 64'(rd_avail), 0);
      chk(wvalid == 1'b0, "R1", "write beat in reset", 64'(wvalid), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_prefill();
      wait_cyc(80);
      chk(n_rcmd == RD / BL, "R1", "fill read command count", 64'(n_rcmd), 64'(RD / BL));
      chk(n_wcmd == 0, "R1", "writes during fill", 64'(n_wcmd), 0);
      for (int j = 0; j < RD / BL; j++)
         chk(rlog[j] == j * BL, "R1", $sformatf("fill address %0d", j), 64'(rlog[j]), 64'(j * BL));
      chk(proc_en == 1'b0, "R2", "enable before vsync", 64'(proc_en), 0);
      chk(rd_avail == 1'b0, "R2", "avail before vsync", 64'(rd_avail), 0);
   endtask

   task automatic t_take_disabled();
      @(negedge clk) take = 1'b1;
      @(negedge clk) take = 1'b0;
      wait_cyc(2);
      chk(uf_err == 1'b0, "R9", "flag after disabled take", 64'(uf_err), 0);
   endtask

   task automatic t_vsync();
      wait_cyc(5);
      chk(proc_en == 1'b0, "R2", "enable with vsync low", 64'(proc_en), 0);
      @(negedge clk) vsync = 1'b1;
      chk(proc_en == 1'b0, "R2", "enable before vsync sampled", 64'(proc_en), 0);
      @(negedge clk);
      chk(proc_en == 1'b1, "R2", "enable after vsync edge", 64'(proc_en), 1);
      chk(rd_avail == 1'b1, "R3", "avail once enabled", 64'(rd_avail), 1);
      chk(rd_data == orig(0), "R9", "first model untouched by disabled take", 64'(rd_data), 64'(orig(0)));
      wait_cyc(3);
      vsync = 1'b0;
   endtask

   task automatic t_first_set();
      run_pixels(SB * BL - 1);
      wait_cyc(20);
      chk(n_wcmd == 0, "R4", "write before staging full", 64'(n_wcmd), 0);
      run_pixels(1);
      wait_cyc(50);
      chk(n_wcmd == SB, "R5", "write command count", 64'(n_wcmd), 64'(SB));
      chk(n_wbeat == SB * BL, "R5", "write beat count", 64'(n_wbeat), 64'(SB * BL));
      for (int j = 0; j < SB; j++)
         chk(wlog[j] == j * BL, "R5", $sformatf("write address %0d", j), 64'(wlog[j]), 64'(j * BL));
      for (int i = 0; i < SB * BL; i++)
         chk(mem_m[i] == (orig(i) ^ MASK), "R5", $sformatf("memory word %0d", i),
             64'(mem_m[i]), 64'(orig(i) ^ MASK));
      chk(n_rcmd == RD / BL + SB, "R6", "refill command count", 64'(n_rcmd), 64'(RD / BL + SB));
      chk(rlog[RD / BL] == RD, "R6", "refill continues address", 64'(rlog[RD / BL]), 64'(RD));
   endtask

   task automatic t_stream_wrap();
      int bad;
      run_pixels(32);
      wait_cyc(80);
      chk(n_wcmd == 10, "R10", "write commands after stream", 64'(n_wcmd), 10);
      chk(n_wbeat == 40, "R10", "write beats after stream", 64'(n_wbeat), 40);
      chk(n_rcmd == 14, "R6", "read commands after stream", 64'(n_rcmd), 14);
      for (int j = 0; j < 10; j++)
         chk(wlog[j] == (j * BL) % FW, "R8", $sformatf("write address wrap %0d", j),
             64'(wlog[j]), 64'((j * BL) % FW));
      for (int j = 0; j < 14; j++)
         chk(rlog[j] == (j * BL) % FW, "R8", $sformatf("read address wrap %0d", j),
             64'(rlog[j]), 64'((j * BL) % FW));
      bad = 0;
      for (int i = 0; i < FW; i++)
         if (mem_m[i] != ((i < 8) ? orig(i) : (orig(i) ^ MASK))) bad++;
      chk(bad == 0, "R10", "words wrong in memory image", 64'(bad), 0);
      chk(hold_viol == 0, "R7", "commands dropped or changed before ready", 64'(hold_viol), 0);
      chk(uf_err == 1'b0, "R9", "flag after clean stream", 64'(uf_err), 0);
   endtask

   task automatic t_underflow();
      int got = 0;
      while (rd_avail && got < 64) begin
         @(negedge clk) take = 1'b1;
         got++;
         @(negedge clk) take = 1'b0;
      end
      chk(got == RD, "R6", "words held in read queue", 64'(got), 64'(RD));
      chk(uf_err == 1'b0, "R9", "flag before empty take", 64'(uf_err), 0);
      @(negedge clk) take = 1'b1;
      @(negedge clk) take = 1'b0;
      chk(uf_err == 1'b1, "R9", "flag after empty take", 64'(uf_err), 1);
      wait_cyc(6);
      chk(uf_err == 1'b1, "R9", "flag stays set", 64'(uf_err), 1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      t_reset();
      t_prefill();
      t_take_disabled();
      t_vsync();
      t_first_set();
      t_stream_wrap();
      t_underflow();
      summary();
      $finish;
   end

endmodule